// File: doc/BRIEF.md
# Central Event Record Store with Colored Counters

This block keeps one record per event number for a network of task-sequencing units. Every record carries a provided flag and a single shared field. For events below a configurable boundary, the field holds the id of the last task that declared it would provide the event. For events at or above the boundary, the field is a use counter measured against one capacity shared by that whole range.

A task declaration arrives as an atomic burst. The requester raises a lock request and waits for the grant. It then sends read beats, which return snapshots of the events the task may wait on, and provide beats, which claim events the task will later release. It ends the burst with a beat marked last. Because only one burst can hold the lock at a time, all declarations are applied in one global order.

Provisions arrive on a separate input at any time, with or without the lock. Each one carries an event number and the id of the providing task. A provision either releases a standard event whose stored provider matches, or counts a colored event down.

Top module: `edf_event_file`

## Requirements
- R1: After reset every record reads back with provided flag 1 and field 0.
- R2: When idle, a high `decl_req` raises `decl_gnt` on the next clock. The grant stays high until the clock after an accepted beat with `decl_last` = 1. A beat offered while the grant is low changes no record.
- R3: A granted beat with `decl_kind` = 0 (read) sets `rd_valid` on the next clock, together with that event's provided flag and field.
- R4: A granted beat with `decl_kind` = 1 (provide) on a standard event clears its provided flag and stores `decl_task` in its field.
- R5: A provide beat on a colored event adds one to its color. The provided flag is cleared when `CAPACITY` <= the new color and is otherwise left unchanged.
- R6: A provision on a standard event sets its provided flag only when `prov_src` equals the stored field. Otherwise the record is left untouched.
- R7: A provision on a colored event takes one from its color and sets the provided flag when `CAPACITY` > the new color. `prov_src` is ignored.
- R8: Event numbers below `COLOR_BASE` are standard. Those from `COLOR_BASE` upward are colored and all share `CAPACITY`.
- R9: When a provision and a provide beat hit the same event in one clock, the provision is applied first and the declaration update is applied to its result.
- R10: The color saturates at its all-ones value on increment and at 0 on decrement. Any saturation pulses `err_sat` high for one clock, one clock later.
- R11: A read beat and a provision to the same event in one clock return the record with the provision already applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decl_req | input | 1 | Lock request for a declaration burst |
| decl_gnt | output | 1 | Lock held; beats are accepted |
| decl_valid | input | 1 | Beat present |
| decl_kind | input | 1 | 0 = read snapshot, 1 = provide claim |
| decl_last | input | 1 | Final beat of the burst |
| decl_event | input | EV_W | Event number of the beat |
| decl_task | input | ID_W | Declaring task id |
| rd_valid | output | 1 | Snapshot returned |
| rd_provided | output | 1 | Snapshot provided flag |
| rd_field | output | FIELD_W | Snapshot source id or color |
| prov_valid | input | 1 | Provision present |
| prov_event | input | EV_W | Provided event number |
| prov_src | input | ID_W | Providing task id |
| err_sat | output | 1 | Color saturation pulse |

## Verification
The grant and `err_sat` each come from one register, so both are due one clock after the stimulus that causes them. The bench drives every input on the falling edge and compares those two outputs on the next falling edge. A read beat's snapshot is also registered once. The bench therefore pushes the expected record into a queue as it drives the beat, and a monitor pops the queue on the falling edge where `rd_valid` is high, so a snapshot that arrives late or early shows up as a miscompare or a leftover entry. Record updates are checked through later read beats, issued at least one clock after the update they observe.

// File: rtl/edf_pkg.sv
package edf_pkg;
   typedef enum logic {
      BEAT_READ    = 1'b0,
      BEAT_PROVIDE = 1'b1
   } beat_kind_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/edf_lock_ctrl.sv
module edf_lock_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic beat_valid,
   input  logic beat_last,
   output logic gnt,
   output logic take
);
   logic locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       locked_q <= 1'b0;
      else if (!locked_q)               locked_q <= req;
      else if (beat_valid && beat_last) locked_q <= 1'b0;
   end

   assign gnt  = locked_q;
   assign take = locked_q && beat_valid;

   // R2: grant follows a request one clock later
   p_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt && req) |=> gnt);
   // R2: last accepted beat releases the lock
   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && beat_last) |=> !gnt);
   // R2: lock is held until the last beat
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && !(beat_valid && beat_last)) |=> gnt);
endmodule

// File: rtl/edf_entry.sv
module edf_entry #(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned COLOR_W  = 3,
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned CAPACITY = 2,
   parameter bit          COLORED  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prov_hit,
   input  logic [ID_W-1:0]    prov_src,
   input  logic               decl_hit,
   input  logic [ID_W-1:0]    decl_task,
   output logic               provided_nx,
   output logic [FIELD_W-1:0] field_nx,
   output logic               sat_err
);
   logic               provided_q;
   logic [FIELD_W-1:0] field_q;

   if (FIELD_W < COLOR_W || FIELD_W < ID_W) begin : g_bad_field
      $error("edf_entry: FIELD_W too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         provided_q <= 1'b1;
         field_q    <= '0;
      end else begin
         provided_q <= provided_nx;
         field_q    <= field_nx;
      end
   end

   if (COLORED) begin : g_colored
      localparam logic [COLOR_W-1:0] CMAX = '1;
      localparam logic [COLOR_W-1:0] CAP  = COLOR_W'(CAPACITY);
      logic [COLOR_W-1:0]  color_q, color_mid, color_end;
      logic                prov_mid, sat_dn, sat_up;
      logic [2*ID_W-1:0]   unused_ids;

      assign unused_ids = {prov_src, decl_task};
      assign color_q    = COLOR_W'(field_q);

      always_comb begin
         sat_dn    = 1'b0;
         sat_up    = 1'b0;
         color_mid = color_q;
         prov_mid  = provided_q;
         if (prov_hit) begin
            if (color_q == '0) sat_dn = 1'b1;
            else               color_mid = color_q - 1'b1;
            if (CAP > color_mid) prov_mid = 1'b1;
         end
         color_end   = color_mid;
         provided_nx = prov_mid;
         if (decl_hit) begin
            if (color_mid == CMAX) sat_up = 1'b1;
            else                   color_end = color_mid + 1'b1;
            if (CAP <= color_end) provided_nx = 1'b0;
         end
      end

      assign field_nx = FIELD_W'(color_end);
      assign sat_err  = sat_dn | sat_up;

      // R5: declaration counts up
      p_color_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (decl_hit && !prov_hit && color_q != CMAX) |=>
            (COLOR_W'(field_q) == $past(color_q) + 1'b1));
      // R5: reaching capacity blocks the event
      p_color_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (decl_hit && !prov_hit && color_q != CMAX && (color_q + 1'b1) >= CAP) |=> !provided_q);
      // R7: provision counts down
      p_color_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (prov_hit && !decl_hit && color_q != '0) |=>
            (COLOR_W'(field_q) == $past(color_q) - 1'b1));
      // R7: below capacity after provision means provided
      p_color_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (prov_hit && !decl_hit && color_q <= CAP) |=> provided_q);
      // R10: increment at the top stays at the top
      p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (decl_hit && !prov_hit && color_q == CMAX) |=> (COLOR_W'(field_q) == CMAX));
      // R10: decrement at zero stays at zero
      p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (prov_hit && !decl_hit && color_q == '0) |=> (COLOR_W'(field_q) == '0));
   end else begin : g_standard
      always_comb begin
         provided_nx = provided_q;
         field_nx    = field_q;
         if (prov_hit && FIELD_W'(prov_src) == field_q) provided_nx = 1'b1;
         if (decl_hit) begin
            provided_nx = 1'b0;
            field_nx    = FIELD_W'(decl_task);
         end
      end
      assign sat_err = 1'b0;

      // R4: declaration claims the event
      p_std_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
         decl_hit |=> (!provided_q && field_q == FIELD_W'($past(decl_task))));
      // R6: foreign provider leaves the record alone
      p_std_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (prov_hit && !decl_hit && FIELD_W'(prov_src) != field_q) |=>
            ($stable(provided_q) && $stable(field_q)));
      // R6: matching provider releases
      p_std_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (prov_hit && !decl_hit && FIELD_W'(prov_src) == field_q) |=> provided_q);
   end
endmodule

// File: rtl/edf_event_file.sv
module edf_event_file #(
   parameter int unsigned NUM_EVENTS = 16,
   parameter int unsigned COLOR_BASE = 12,
   parameter int unsigned ID_W       = 4,
   parameter int unsigned COLOR_W    = 3,
   parameter int unsigned CAPACITY   = 2,
   localparam int unsigned EV_W      = $clog2(NUM_EVENTS),
   localparam int unsigned FIELD_W   = edf_pkg::max_u(ID_W, COLOR_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               decl_req,
   output logic               decl_gnt,
   input  logic               decl_valid,
   input  logic               decl_kind,
   input  logic               decl_last,
   input  logic [EV_W-1:0]    decl_event,
   input  logic [ID_W-1:0]    decl_task,
   output logic               rd_valid,
   output logic               rd_provided,
   output logic [FIELD_W-1:0] rd_field,
   input  logic               prov_valid,
   input  logic [EV_W-1:0]    prov_event,
   input  logic [ID_W-1:0]    prov_src,
   output logic               err_sat
);
   import edf_pkg::*;

   if (NUM_EVENTS < 2) begin : g_bad_count
      $error("edf_event_file: NUM_EVENTS must be at least 2");
   end
   if (COLOR_BASE > NUM_EVENTS) begin : g_bad_base
      $error("edf_event_file: COLOR_BASE beyond event range");
   end
   if (CAPACITY < 1 || CAPACITY > (2**COLOR_W) - 1) begin : g_bad_cap
      $error("edf_event_file: CAPACITY out of color range");
   end

   beat_kind_e         kind;
   logic               take;
   logic [NUM_EVENTS-1:0] prov_hit, decl_hit, sat_vec, prov_nx;
   logic [FIELD_W-1:0] field_nx [NUM_EVENTS];
   logic               ev_in_range;

   assign kind        = beat_kind_e'(decl_kind);
   assign ev_in_range = (32'(decl_event) < NUM_EVENTS);

   edf_lock_ctrl u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (decl_req),
      .beat_valid (decl_valid),
      .beat_last  (decl_last),
      .gnt        (decl_gnt),
      .take       (take)
   );

   for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_rec
      localparam bit IS_COL = (i >= COLOR_BASE);
      assign prov_hit[i] = prov_valid && (prov_event == EV_W'(i));
      assign decl_hit[i] = take && (kind == BEAT_PROVIDE) && (decl_event == EV_W'(i));

      edf_entry #(
         .ID_W     (ID_W),
         .COLOR_W  (COLOR_W),
         .FIELD_W  (FIELD_W),
         .CAPACITY (CAPACITY),
         .COLORED  (IS_COL)
      ) u_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .prov_hit    (prov_hit[i]),
         .prov_src    (prov_src),
         .decl_hit    (decl_hit[i]),
         .decl_task   (decl_task),
         .provided_nx (prov_nx[i]),
         .field_nx    (field_nx[i]),
         .sat_err     (sat_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_provided <= 1'b0;
         rd_field    <= '0;
         err_sat     <= 1'b0;
      end else begin
         rd_valid <= take && (kind == BEAT_READ);
         err_sat  <= |sat_vec;
         if (take && (kind == BEAT_READ) && ev_in_range) begin
            rd_provided <= prov_nx[decl_event];
            rd_field    <= field_nx[decl_event];
         end
      end
   end

   // R3: snapshot follows a granted read beat
   p_read_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (decl_gnt && decl_valid && decl_kind == 1'b0) |=> rd_valid);
   // R3: no snapshot without a granted read beat
   p_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (decl_gnt && !(decl_valid && decl_kind == 1'b0)) |=> !rd_valid);
   // R2: an ungranted beat never yields a snapshot
   p_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !decl_gnt |=> !rd_valid);
endmodule

// File: tb/edf_event_file_tb_top.sv
`timescale 1ns/1ps
module edf_event_file_tb_top;
   localparam int NE = 16, CB = 12, IDW = 4, CW = 3, CAP = 2, FW = 4, EW = 4;
   localparam int CMAXV = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic decl_req, decl_gnt, decl_valid, decl_kind, decl_last;
   logic [EW-1:0]  decl_event, prov_event;
   logic [IDW-1:0] decl_task, prov_src;
   logic rd_valid, rd_provided, prov_valid, err_sat;
   logic [FW-1:0] rd_field;

   always #2.5 clk = ~clk;

   edf_event_file #(.NUM_EVENTS(NE), .COLOR_BASE(CB), .ID_W(IDW), .COLOR_W(CW), .CAPACITY(CAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .decl_req(decl_req), .decl_gnt(decl_gnt),
      .decl_valid(decl_valid), .decl_kind(decl_kind), .decl_last(decl_last),
      .decl_event(decl_event), .decl_task(decl_task), .rd_valid(rd_valid),
      .rd_provided(rd_provided), .rd_field(rd_field), .prov_valid(prov_valid),
      .prov_event(prov_event), .prov_src(prov_src), .err_sat(err_sat));

   typedef struct {
      logic    p;
      int      f;
      int      ev;
      string   req;
   } snap_t;

   snap_t sbq[$];
   int    n_checks = 0, n_fail = 0;
   bit    done = 1'b0, mgnt = 1'b0;
   bit    m_prov [NE];
   int    m_field [NE];

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference: provision on the model (R6, R7, R10)
   function automatic bit model_prov(input int e, input int s);
      bit sat = 1'b0;
      if (e < CB) begin
         if (m_field[e] == s) m_prov[e] = 1'b1;
      end else begin
         if (m_field[e] == 0) sat = 1'b1;
         else m_field[e]--;
         if (CAP > m_field[e]) m_prov[e] = 1'b1;
      end
      return sat;
   endfunction

   // reference: provide beat on the model (R4, R5, R10)
   function automatic bit model_decl(input int e, input int t);
      bit sat = 1'b0;
      if (e < CB) begin
         m_prov[e]  = 1'b0;
         m_field[e] = t;
      end else begin
         if (m_field[e] == CMAXV) sat = 1'b1;
         else m_field[e]++;
         if (CAP <= m_field[e]) m_prov[e] = 1'b0;
      end
      return sat;
   endfunction

   task automatic tick(input bit req, input bit bv, input bit bk, input int be, input int bt,
                       input bit bl, input bit pv, input int pe, input int ps, input string tag);
      bit sat = 1'b0;
      bit nxt, exp_rv;
      decl_req = req; decl_valid = bv; decl_kind = bk; decl_event = EW'(be);
      decl_task = IDW'(bt); decl_last = bl; prov_valid = pv; prov_event = EW'(pe); prov_src = IDW'(ps);
      if (pv) sat |= model_prov(pe, ps);                 // R9: provision first
      exp_rv = mgnt && bv && !bk;
      if (mgnt && bv) begin
         if (!bk) sbq.push_back('{m_prov[be], m_field[be], be, tag});
         else     sat |= model_decl(be, bt);
      end
      nxt = mgnt ? !(bv && bl) : req;
      @(negedge clk);
      mgnt = nxt;
      check(decl_gnt == mgnt, "R2", "grant", int'(decl_gnt), int'(mgnt));
      check(err_sat == sat, "R10", "saturation pulse", int'(err_sat), int'(sat));
      check(rd_valid == exp_rv, "R3", "snapshot valid", int'(rd_valid), int'(exp_rv));
      decl_valid = 1'b0; prov_valid = 1'b0; decl_req = 1'b0;
   endtask

   task automatic idle();                       tick(0,0,0,0,0,0,0,0,0,""); endtask
   task automatic lock();                       tick(1,0,0,0,0,0,0,0,0,""); endtask
   task automatic rd(input int e, input string tag, input bit last); tick(0,1,0,e,0,last,0,0,0,tag); endtask
   task automatic dcl(input int e, input int t, input bit last);     tick(0,1,1,e,t,last,0,0,0,""); endtask
   task automatic prov(input int e, input int s);                    tick(0,0,0,0,0,0,1,e,s,""); endtask

   // monitor: compares returned snapshots against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rd_valid === 1'b1) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R3", "unexpected snapshot", 1, 0);
         end else begin
            snap_t x;
            x = sbq.pop_front();
            check(rd_provided == x.p, x.req, $sformatf("provided of event %0d", x.ev),
                  int'(rd_provided), int'(x.p));
            check(int'(rd_field) == x.f, x.req, $sformatf("field of event %0d", x.ev),
                  int'(rd_field), x.f);
         end
      end
   end

   initial begin
      rst_n = 1'b0; decl_req = 0; decl_valid = 0; decl_kind = 0; decl_last = 0;
      decl_event = '0; decl_task = '0; prov_valid = 0; prov_event = '0; prov_src = '0;
      for (int i = 0; i < NE; i++) begin m_prov[i] = 1'b1; m_field[i] = 0; end
      repeat (3) @(negedge clk);
      check(decl_gnt == 1'b0, "R1", "grant in reset", int'(decl_gnt), 0);
      check(rd_valid == 1'b0, "R1", "snapshot in reset", int'(rd_valid), 0);
      check(err_sat == 1'b0, "R1", "error in reset", int'(err_sat), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every record starts provided with field 0
      lock();
      for (int e = 0; e < NE; e++) rd(e, "R1", e == NE - 1);
      idle();

      // R2: a beat without grant is ignored
      dcl(3, 5, 1);
      lock(); rd(3, "R2", 1);

      // R4 / R8: standard claims, including the last standard event
      lock(); dcl(3, 5, 0); dcl(5, 9, 0); dcl(CB - 1, 6, 0);
      rd(3, "R4", 0); rd(CB - 1, "R8", 1);

      // R6: foreign provider, then matching provider
      prov(3, 7);
      lock(); rd(3, "R6", 1);
      prov(3, 5);
      lock(); rd(3, "R6", 1);

      // R5 / R8: colored counting against the shared capacity
      lock(); dcl(CB, 1, 0); rd(CB, "R5", 0); dcl(CB, 1, 0); rd(CB, "R5", 0); rd(CB + 1, "R8", 1);

      // R7: provision counts down and releases
      prov(CB, 0);
      lock(); rd(CB, "R7", 1);

      // R10: decrement at zero
      prov(CB + 1, 0);
      lock(); rd(CB + 1, "R10", 1);

      // R10: increment at the top
      lock();
      for (int k = 0; k <= CMAXV; k++) dcl(CB + 2, 3, 0);
      rd(CB + 2, "R10", 1);

      // R9: provision and claim on one standard event in one clock
      lock();
      tick(0,1,1,5,2,0,1,5,9,"");
      rd(5, "R9", 1);

      // R11: read and provision on one colored event in one clock
      lock();
      tick(0,1,0,CB,0,1,1,CB,0,"R11");

      // R9: colored count down then up in one clock at the top
      lock();
      tick(0,1,1,CB + 2,0,0,1,CB + 2,0,"");
      rd(CB + 2, "R9", 1);

      repeat (3) idle();
      check(sbq.size() == 0, "R3", "snapshots outstanding", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule